// File: doc/BRIEF.md
# System Controller Register Block

This block is a small memory-mapped system controller. Software reaches it through a 32-bit register port. The byte address is divided by four to give a word index, and only whole-word accesses are meaningful. The block holds the general-purpose output pins and their interrupt-enable mask. It samples the general-purpose input pins through a synchronizer. It has a scratch word, a sticky lock flag, and read-only words that describe the platform: clock rate, capability bits and an identity code.

Two compare timers count up once per clock while enabled. Each one raises its own interrupt line when its count reaches its compare value. It then either stops or starts again from zero, as its control word selects.

Two writes reach outside the block. A command word written to the configuration-port register raises a one-cycle shutdown request. Any write to the identity register raises a one-cycle reset request. The logic that acts on those requests lives elsewhere.

Top module: `sys_ctrl_regs`

## Requirements
- R1: After reset the registers read as follows. The configuration port (index 16) reads 1, where bit 0 is the ready flag. The identity word (index 31) reads 0x10014D31, the clock-rate word (index 29) reads 80000000, and the capability word (index 30) reads 0. The input-pin word (index 0) reads 0x00000001 until sampled pins replace it. Every other register reads 0, and the pin, interrupt and request outputs are low.
- R2: The word index is byte address bits [6:2], and address bits [1:0] are ignored. The map is: input pins 0, output pins 1, pin interrupt mask 2, timer A control/compare/count 4/5/6, timer B control/compare/count 8/9/10, configuration port 16, scratch 20, lock 21, clock rate 29, capabilities 30, identity 31.
- R3: A read strobe returns the addressed word on the read-data port one clock later, qualified by a one-cycle read-valid flag. The returned word holds the values from before the strobe's clock edge.
- R4: Writes to the input-pin, clock-rate, capability and identity words leave their read values unchanged.
- R5: The output-pin word, the interrupt-mask word and the scratch word read back what was last written. The output-pin word and the mask word drive their output ports.
- R6: The input-pin word shows the input pins after a two-flop synchronizer. A pin change is seen by a read whose strobe is at least two clocks after the change.
- R7: Any write to the lock word makes it read 1, whatever the data; only reset clears it.
- R8: A write to the configuration port whose data bits [15:0] equal 0x000E raises shutdown_req_o for exactly one clock. Any other data raises nothing. The port keeps reading 1.
- R9: Any write to the identity word raises reset_req_o for exactly one clock.
- R10: The timer control word uses bit 0 as enable and bit 1 as auto-restart, and its other bits read 0. An enabled timer adds 1 to its count on each clock. The count can be read and written, and a disabled timer holds its count.
- R11: An enabled timer whose count is at or above its compare value fires: its interrupt line pulses high on the next clock. In one-shot mode the enable bit clears and the count stays put. In auto-restart mode the count returns to 0, so the period is compare+1 clocks.
- R12: The two timers run independently, and each drives only its own interrupt output.
- R13: Reads of unmapped indices return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_wr_en_i | input | 1 | Write strobe, one clock per access |
| bus_rd_en_i | input | 1 | Read strobe, one clock per access |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one clock after the strobe |
| gpio_pins_i | input | GPIO_W | Asynchronous input pins |
| gpio_pins_o | output | GPIO_W | Output pin levels |
| gpio_irq_en_o | output | GPIO_W | Pin interrupt mask for the external pin-interrupt logic |
| tmr0_irq_o | output | 1 | Timer A fire pulse |
| tmr1_irq_o | output | 1 | Timer B fire pulse |
| shutdown_req_o | output | 1 | One-clock shutdown request |
| reset_req_o | output | 1 | One-clock system reset request |

## Verification
The assertions assume that each access strobe lasts a single clock. They also assume the address and write data are stable while the strobe is high, and that reset is held for at least two clocks so the synchronizer and timers start from known values. The stimulus drives every strobe for exactly one clock, between falling edges, and it changes the input pins only on a falling edge. Timer runs use nonzero compare values, so no timer fires on every clock and the pulse checks stay meaningful.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DW    = 32;
  localparam int IDX_W = 5;

  // register word indices
  localparam logic [IDX_W-1:0] IX_GPIO_IN  = 5'd0;
  localparam logic [IDX_W-1:0] IX_GPIO_OUT = 5'd1;
  localparam logic [IDX_W-1:0] IX_GPIO_IEN = 5'd2;
  localparam logic [IDX_W-1:0] IX_CFG      = 5'd16;
  localparam logic [IDX_W-1:0] IX_SCRATCH  = 5'd20;
  localparam logic [IDX_W-1:0] IX_LOCK     = 5'd21;
  localparam logic [IDX_W-1:0] IX_FREQ     = 5'd29;
  localparam logic [IDX_W-1:0] IX_CAPS     = 5'd30;
  localparam logic [IDX_W-1:0] IX_SYSID    = 5'd31;

  // timer bank layout: base + k*stride + offset
  localparam int NUM_TMR    = 2;
  localparam int TMR_BASE   = 4;
  localparam int TMR_STRIDE = 4;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_CMP    = 1;
  localparam int OFS_CNT    = 2;

  localparam logic [15:0]   CMD_SHUTDOWN = 16'h000E;
  localparam logic [DW-1:0] CFG_READY    = 32'h0000_0001;

  typedef struct packed {
    logic autorst;  // bit 1
    logic en;       // bit 0
  } tmr_ctrl_t;

  function automatic logic [IDX_W-1:0] tmr_idx(input int k, input int ofs);
    return IDX_W'(TMR_BASE + k * TMR_STRIDE + ofs);
  endfunction

endpackage

// File: rtl/sysctl_insync.sv
module sysctl_insync #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  AST_SYNC_TWO: assert property (@(posedge clk_i) disable iff (rst_i)
    (q_o != $past(q_o)) |-> (q_o == $past(d_i, 2))); // R6

endmodule

// File: rtl/sysctl_tmr.sv
module sysctl_tmr
  import sysctl_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          wr_ctrl_i,
  input  logic          wr_cmp_i,
  input  logic          wr_cnt_i,
  input  logic [CW-1:0] wdata_i,
  output tmr_ctrl_t     ctrl_o,
  output logic [CW-1:0] cmp_o,
  output logic [CW-1:0] cnt_o,
  output logic          irq_o
);

  tmr_ctrl_t     ctrl_q;
  logic [CW-1:0] cmp_q;
  logic [CW-1:0] cnt_q;
  logic          irq_q;
  logic          hit;

  assign hit = ctrl_q.en && (cnt_q >= cmp_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= hit;

      if (wr_ctrl_i) begin
        ctrl_q.en      <= wdata_i[0];
        ctrl_q.autorst <= wdata_i[1];
      end else if (hit && !ctrl_q.autorst) begin
        ctrl_q.en <= 1'b0;
      end

      if (wr_cmp_i) cmp_q <= wdata_i;

      if (wr_cnt_i) begin
        cnt_q <= wdata_i;
      end else if (hit) begin
        if (ctrl_q.autorst) cnt_q <= '0;
      end else if (ctrl_q.en) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;

  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_q.en && !hit && !wr_cnt_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R10
  AST_TMR_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ctrl_q.en && !wr_cnt_i) |=> $stable(cnt_q)); // R10
  AST_TMR_ONESHOT: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit && !ctrl_q.autorst && !wr_ctrl_i) |=> !ctrl_q.en); // R11
  AST_TMR_IRQ_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> $past(ctrl_q.en)); // R11

endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sysctl_pkg::*;
#(
  parameter int              ADDR_W     = 7,
  parameter int              GPIO_W     = 32,
  parameter logic [GPIO_W-1:0] GPIO_STRAP = 'h1,
  parameter logic [31:0]     CLK_HZ     = 32'd80000000,
  parameter logic [31:0]     CAPS       = 32'h0,
  parameter logic [31:0]     SYS_ID     = 32'h10014D31
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bus_wr_en_i,
  input  logic              bus_rd_en_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [GPIO_W-1:0] gpio_pins_i,
  output logic [GPIO_W-1:0] gpio_pins_o,
  output logic [GPIO_W-1:0] gpio_irq_en_o,
  output logic              tmr0_irq_o,
  output logic              tmr1_irq_o,
  output logic              shutdown_req_o,
  output logic              reset_req_o
);

  localparam int WIX_W = ADDR_W - 2;

  function automatic logic [WIX_W-1:0] ix(input logic [IDX_W-1:0] v);
    return WIX_W'(v);
  endfunction

  logic [WIX_W-1:0]  idx;
  logic [GPIO_W-1:0] gpio_in_q;
  logic [GPIO_W-1:0] gpio_out_q;
  logic [GPIO_W-1:0] gpio_ien_q;
  logic [DW-1:0]     scratch_q;
  logic              lock_q;
  logic              shdn_q;
  logic              rreq_q;
  logic [DW-1:0]     rdata_q;
  logic              rvalid_q;
  logic [DW-1:0]     rd_mux;

  tmr_ctrl_t         t_ctrl [NUM_TMR];
  logic [DW-1:0]     t_cmp  [NUM_TMR];
  logic [DW-1:0]     t_cnt  [NUM_TMR];
  logic [NUM_TMR-1:0] t_irq;

  assign idx = bus_addr_i[ADDR_W-1:2];

  sysctl_insync #(.W(GPIO_W), .RST_VAL(GPIO_STRAP)) u_insync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (gpio_pins_i),
    .q_o   (gpio_in_q)
  );

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    logic wr_ctrl, wr_cmp, wr_cnt;
    assign wr_ctrl = bus_wr_en_i && (idx == ix(tmr_idx(k, OFS_CTRL)));
    assign wr_cmp  = bus_wr_en_i && (idx == ix(tmr_idx(k, OFS_CMP)));
    assign wr_cnt  = bus_wr_en_i && (idx == ix(tmr_idx(k, OFS_CNT)));

    sysctl_tmr #(.CW(DW)) u_tmr (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .wr_ctrl_i (wr_ctrl),
      .wr_cmp_i  (wr_cmp),
      .wr_cnt_i  (wr_cnt),
      .wdata_i   (bus_wdata_i),
      .ctrl_o    (t_ctrl[k]),
      .cmp_o     (t_cmp[k]),
      .cnt_o     (t_cnt[k]),
      .irq_o     (t_irq[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      ix(IX_GPIO_IN):  rd_mux = DW'(gpio_in_q);
      ix(IX_GPIO_OUT): rd_mux = DW'(gpio_out_q);
      ix(IX_GPIO_IEN): rd_mux = DW'(gpio_ien_q);
      ix(IX_CFG):      rd_mux = CFG_READY;
      ix(IX_SCRATCH):  rd_mux = scratch_q;
      ix(IX_LOCK):     rd_mux = DW'(lock_q);
      ix(IX_FREQ):     rd_mux = CLK_HZ;
      ix(IX_CAPS):     rd_mux = CAPS;
      ix(IX_SYSID):    rd_mux = SYS_ID;
      default:         rd_mux = '0;
    endcase
    for (int k = 0; k < NUM_TMR; k++) begin
      if (idx == ix(tmr_idx(k, OFS_CTRL))) rd_mux = DW'(t_ctrl[k]);
      if (idx == ix(tmr_idx(k, OFS_CMP)))  rd_mux = t_cmp[k];
      if (idx == ix(tmr_idx(k, OFS_CNT)))  rd_mux = t_cnt[k];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gpio_out_q <= '0;
      gpio_ien_q <= '0;
      scratch_q  <= '0;
      lock_q     <= 1'b0;
      shdn_q     <= 1'b0;
      rreq_q     <= 1'b0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
    end else begin
      shdn_q   <= bus_wr_en_i && (idx == ix(IX_CFG)) &&
                  (bus_wdata_i[15:0] == CMD_SHUTDOWN);
      rreq_q   <= bus_wr_en_i && (idx == ix(IX_SYSID));
      rvalid_q <= bus_rd_en_i;
      if (bus_rd_en_i) rdata_q <= rd_mux;
      if (bus_wr_en_i) begin
        case (idx)
          ix(IX_GPIO_OUT): gpio_out_q <= bus_wdata_i[GPIO_W-1:0];
          ix(IX_GPIO_IEN): gpio_ien_q <= bus_wdata_i[GPIO_W-1:0];
          ix(IX_SCRATCH):  scratch_q  <= bus_wdata_i;
          ix(IX_LOCK):     lock_q     <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign bus_rdata_o    = rdata_q;
  assign bus_rvalid_o   = rvalid_q;
  assign gpio_pins_o    = gpio_out_q;
  assign gpio_irq_en_o  = gpio_ien_q;
  assign tmr0_irq_o     = t_irq[0];
  assign tmr1_irq_o     = t_irq[1];
  assign shutdown_req_o = shdn_q;
  assign reset_req_o    = rreq_q;

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
    bus_rd_en_i |=> bus_rvalid_o); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    lock_q |=> lock_q); // R7
  AST_SHDN_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    shutdown_req_o |=> !shutdown_req_o); // R8
  AST_SHDN_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    shutdown_req_o |-> $past(bus_wr_en_i)); // R8
  AST_RREQ_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    reset_req_o |=> !reset_req_o); // R9
  AST_RREQ_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    reset_req_o |-> $past(bus_wr_en_i)); // R9

endmodule

// File: tb/sim_sys_ctrl_regs.sv
module sim_sys_ctrl_regs;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 7;
  localparam int GPIO_W = 32;
  localparam logic [31:0] ID_VAL = 32'h10014D31;

  logic              clk = 1'b0;
  logic              rst;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic              rvalid;
  logic [GPIO_W-1:0] pins_in, pins_out, irq_en;
  logic              irq0, irq1, shdn, rreq;

  int n_cmp  = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  sys_ctrl_regs #(.ADDR_W(ADDR_W), .GPIO_W(GPIO_W)) u0 (
    .clk_i(clk), .rst_i(rst),
    .bus_wr_en_i(wr_en), .bus_rd_en_i(rd_en), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .gpio_pins_i(pins_in), .gpio_pins_o(pins_out), .gpio_irq_en_o(irq_en),
    .tmr0_irq_o(irq0), .tmr1_irq_o(irq1),
    .shutdown_req_o(shdn), .reset_req_o(rreq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; addr = ADDR_W'(a);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_fail++;
        $display("FAIL R3: unexpected read data %h expected none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wrap_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    wrap_up();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pins_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, 32'h1, "R1 gpio-in strap");
    chk(pins_out, 32'h0, "R1 pins out");
    chk({31'b0, shdn}, 32'h0, "R1 shutdown idle");
    chk({31'b0, rreq}, 32'h0, "R1 reset-req idle");
    rd(16*4, 32'h1, "R1 config ready");
    rd(31*4, ID_VAL, "R1 id");
    rd(29*4, 32'd80000000, "R1 clock rate");
    rd(30*4, 32'h0, "R1 caps");
    rd(1*4, 32'h0, "R1 gpio out");
    rd(2*4, 32'h0, "R1 mask");
    rd(20*4, 32'h0, "R1 scratch");
    rd(21*4, 32'h0, "R1 lock");
    rd(4*4, 32'h0, "R1 tmrA ctrl");
    rd(6*4, 32'h0, "R1 tmrA count");
    rd(9*4, 32'h0, "R1 tmrB compare");

    // R2 low address bits ignored
    rd(7'h7D, ID_VAL, "R2 byte offset ignored");

    // R5 read/write registers
    wr(1*4, 32'hA5A5_0F0F);
    chk(pins_out, 32'hA5A5_0F0F, "R5 pins driven");
    rd(1*4, 32'hA5A5_0F0F, "R5 gpio out readback");
    wr(2*4, 32'h0000_00FF);
    chk(irq_en, 32'h0000_00FF, "R5 mask driven");
    rd(2*4, 32'h0000_00FF, "R5 mask readback");
    wr(20*4, 32'hDEAD_BEEF);
    rd(20*4, 32'hDEAD_BEEF, "R5 scratch");

    // R4 read-only words
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0, "R4 gpio-in write ignored");
    wr(29*4, 32'h0);
    rd(29*4, 32'd80000000, "R4 clock rate write ignored");
    wr(30*4, 32'hFFFF_FFFF);
    rd(30*4, 32'h0, "R4 caps write ignored");

    // R9 reset request
    wr(31*4, 32'h0);
    chk({31'b0, rreq}, 32'h1, "R9 reset-req pulse");
    chk({31'b0, shdn}, 32'h0, "R9 no shutdown");
    @(negedge clk);
    chk({31'b0, rreq}, 32'h0, "R9 single cycle");
    rd(31*4, ID_VAL, "R4 id unchanged");

    // R7 lock
    wr(21*4, 32'h0);
    rd(21*4, 32'h1, "R7 lock set by zero");
    wr(21*4, 32'hFFFF_FFFE);
    rd(21*4, 32'h1, "R7 lock stays 1");

    // R8 shutdown command
    wr(16*4, 32'h0000_000F);
    chk({31'b0, shdn}, 32'h0, "R8 other value");
    wr(16*4, 32'h000E_0000);
    chk({31'b0, shdn}, 32'h0, "R8 high half only");
    wr(16*4, 32'h1234_000E);
    chk({31'b0, shdn}, 32'h1, "R8 shutdown pulse");
    @(negedge clk);
    chk({31'b0, shdn}, 32'h0, "R8 single cycle");
    rd(16*4, 32'h1, "R8 ready kept");

    // R13 unmapped
    wr(3*4, 32'h1234_5678);
    rd(3*4, 32'h0, "R13 unmapped write/read");
    rd(25*4, 32'h0, "R13 unmapped read");
    rd(20*4, 32'hDEAD_BEEF, "R13 scratch untouched");

    // R6 synchronizer latency
    pins_in = 32'h0000_00C3;
    rd(0, 32'h0, "R6 not yet (1)");
    rd(0, 32'h0, "R6 not yet (2)");
    rd(0, 32'h0000_00C3, "R6 visible");

    // R10 count-up
    wr(5*4, 32'd1000);
    wr(4*4, 32'h1);
    repeat (7) @(negedge clk);
    rd(6*4, 32'd7, "R10 count after 7 clocks");
    rd(4*4, 32'h1, "R10 ctrl readback");
    wr(4*4, 32'h0);
    rd(6*4, 32'd10, "R10 held after disable");
    rd(6*4, 32'd10, "R10 still held");
    wr(6*4, 32'd3);
    rd(6*4, 32'd3, "R10 count write");
    rd(10*4, 32'h0, "R12 timer B untouched");

    // R11 one-shot, timer A, compare 5
    wr(5*4, 32'd5);
    wr(6*4, 32'd0);
    wr(4*4, 32'h1);
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      chk({31'b0, irq0}, {31'b0, (i == 6)}, "R11 one-shot irq");
      chk({31'b0, irq1}, 32'h0, "R12 timer B quiet");
    end
    rd(4*4, 32'h0, "R11 enable cleared");
    rd(6*4, 32'd5, "R11 count held");

    // R11 auto-restart, timer B, compare 3
    wr(9*4, 32'd3);
    wr(10*4, 32'd0);
    wr(8*4, 32'h3);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk({31'b0, irq1}, {31'b0, (i == 4 || i == 8)}, "R11 auto-restart irq");
      chk({31'b0, irq0}, 32'h0, "R12 timer A quiet");
    end
    rd(8*4, 32'h3, "R11 still enabled");
    wr(8*4, 32'h0);

    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 32'h0, "R3 all reads answered");
    wrap_up();
  end

endmodule